// File: doc/BRIEF.md
# LIN Bus Master Frame Engine

This block runs the master side of a LIN bus frame without software stepping through it. Software sees a small register window: it selects a register with an address, then writes or reads one byte. Through that window it loads a 6-bit frame identifier, a byte count, a checksum flavour, a direction and up to eight payload bytes. A write with the start bit set launches the frame. The engine drives the header on its transmit pin: a long dominant break, a synchronisation byte and the protected identifier. It then either sends the payload and checksum, or collects the payload and checksum from its receive pin and verifies them.

When the frame ends, a done flag or an error flag is set and the interrupt line is raised. The line stays high until software clears it through the control register. The bit rate is a fixed divisor of the clock. Every character is sent and received as one low start bit, eight data bits with the least significant bit first, and one high stop bit.

Top module: `lin_master_ctl`

## Requirements
- R1: A frame begins with a break of BREAK_BITS bit times low, then one high bit. Next comes the byte 0x55, then the protected identifier. Each byte is framed as start(0), eight data bits LSB first, stop(1), and every bit lasts BIT_DIV clocks.
- R2: The protected identifier is id[5:0] in bits 5:0. Bit 6 is id0^id1^id2^id4 and bit 7 is ~(id1^id3^id4^id5).
- R3: The register window has these reads and writes:
  - Addresses 0x0-0x7 are the payload bytes.
  - Address 0x8 is control. Bit 5 is direction and reads back. Bits 0, 2 and 3 are strobes and read as 0.
  - Address 0x9 is status (read only).
  - Address 0xB is size. It keeps bits 7 and 3:0; the other bits read as 0.
  - Address 0xE is the identifier. It keeps bits 5:0.
- R4: The payload length comes from size[3:0]. Values 0-8 are used as given. Values 9-14 mean 8. The value 15 decodes the length from id[5:4]: 00 and 01 give 2 bytes, 10 gives 4 bytes, 11 gives 8 bytes.
- R5: With direction 1 (transmit), the payload bytes go out in order from address 0x0 upward, right after the identifier, and the checksum byte follows them.
- R6: The checksum is the bit inverse of an 8-bit sum whose carry is added back in. With size bit 7 = 0 (classic) it covers the payload only. With size bit 7 = 1 (enhanced) the protected identifier is also in the sum.
- R7: With direction 0 (receive), the received payload bytes are stored at addresses 0x0 upward. A matching checksum byte ends the frame with done set.
- R8: In receive, a checksum mismatch ends the frame with error set. So does a stop bit read as 0, and that frame ends at that byte.
- R9: In receive, if no start bit arrives within TIMEOUT_BITS bit times of the previous event, the frame ends with error set.
- R10: Status bit 0 is done and bit 2 is error. The interrupt rises when a frame ends. Writing control bit 3 clears the interrupt and done. Writing control bit 2 clears error only.
- R11: A start request written while a frame is in progress is ignored: no second frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register window address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register (combinational) |
| lin_tx | output | 1 | Bus transmit line, high when idle |
| lin_rx | input | 1 | Bus receive line |
| irq | output | 1 | Interrupt request, held until cleared |

## Verification
The embedded assertions check several things on every clock. The serializer is never launched while it is busy. The identifier state is always entered straight from the sync state. The receiver is only armed for receive frames, and a receive timeout only comes from an armed receiver. The frame length never exceeds eight. The interrupt only rises together with a done or error flag.

The bench scenarios cover the things that need whole frames to show. They decode the transmit line and compare the break length, identifier parity, payload order and both checksum flavours against values computed in the bench, across every identifier and every size code. They also play a slave on the receive line to reach a good checksum, a corrupted checksum, a bad stop bit, silence and the status clearing rules.

// File: rtl/lin_pkg.sv
// Shared definitions for the LIN master engine.
// Holds the register window offsets, the control bit positions, the frame
// sequencer state type, and pure helper functions (parity, length, checksum).
package lin_pkg;

    localparam int PAT_W   = 16;   // widest serial pattern (break plus delimiter)
    localparam int NBUF    = 8;    // payload buffer depth

    localparam logic [3:0] A_CTRL = 4'h8;
    localparam logic [3:0] A_STAT = 4'h9;
    localparam logic [3:0] A_SIZE = 4'hB;
    localparam logic [3:0] A_IDEN = 4'hE;

    localparam int C_START  = 0;
    localparam int C_CLRERR = 2;
    localparam int C_CLRIRQ = 3;
    localparam int C_DIR    = 5;

    typedef enum logic [2:0] {
        S_IDLE, S_BRK, S_SYN, S_PID, S_TXD, S_TXC, S_RXD, S_RXC
    } seq_state_t;

    // Protected identifier: two parity bits above the 6-bit identifier.
    function automatic logic [7:0] lin_pid(input logic [5:0] id);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0, id};
    endfunction

    // Payload length from the size nibble, decoding 4'hF from the identifier.
    function automatic logic [3:0] lin_len(input logic [3:0] nib, input logic [5:0] id);
        if (nib == 4'hF) begin
            case (id[5:4])
                2'b10:   return 4'd4;
                2'b11:   return 4'd8;
                default: return 4'd2;
            endcase
        end
        return (nib > 4'd8) ? 4'd8 : nib;
    endfunction

    // One step of the carry-folding 8-bit sum.
    function automatic logic [7:0] csum_add(input logic [7:0] acc, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, acc} + {1'b0, b};
        return s[7:0] + {7'b0, s[8]};
    endfunction

endpackage

// File: rtl/lin_bit_tx.sv
// Serial pattern shifter for the bus transmit line.
// Sends nbits bits of pat, LSB first, each held BIT_DIV clocks; the line
// idles high. Assumes go is only raised while the shifter is idle; done
// pulses for one clock when the last bit has ended.
module lin_bit_tx #(
    parameter int BIT_DIV = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go,
    input  logic [lin_pkg::PAT_W-1:0]     pat,
    input  logic [$clog2(lin_pkg::PAT_W+1)-1:0] nbits,
    output logic                          done,
    output logic                          line
);
    localparam int DW = $clog2(BIT_DIV + 1);
    localparam int NW = $clog2(lin_pkg::PAT_W + 1);

    logic                       busy;
    logic [lin_pkg::PAT_W-1:0]  shreg;
    logic [NW-1:0]              left;
    logic [DW-1:0]              div;

    // Load a pattern, then shift one bit out every BIT_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            shreg <= '0;
            left  <= '0;
            div   <= '0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                busy  <= 1'b1;
                shreg <= pat;
                left  <= nbits;
                div   <= '0;
            end else if (busy) begin
                if (div == DW'(BIT_DIV - 1)) begin
                    div   <= '0;
                    shreg <= shreg >> 1;
                    left  <= left - NW'(1);
                    if (left == NW'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    div <= div + DW'(1);
                end
            end
        end
    end

    assign line = busy ? shreg[0] : 1'b1;

    // R1: the sequencer never launches a new pattern over one in flight.
    assert_go_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);

endmodule

// File: rtl/lin_byte_rx.sv
// Byte receiver for the bus receive line.
// While arm is high it waits for a low start bit, samples it at mid-bit,
// then samples eight data bits (LSB first) and the stop bit. A high stop
// gives byte_vld, a low stop gives frame_err. If no start bit appears
// within TIMEOUT_BITS bit times, timeout pulses. Assumes BIT_DIV >= 2.
module lin_byte_rx #(
    parameter int BIT_DIV      = 16,
    parameter int TIMEOUT_BITS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       rx_pin,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       frame_err,
    output logic       timeout
);
    localparam int DW      = $clog2(BIT_DIV + 1);
    localparam int HALF    = BIT_DIV / 2;
    localparam int TMO_CYC = TIMEOUT_BITS * BIT_DIV;
    localparam int TW      = $clog2(TMO_CYC + 1);

    typedef enum logic [1:0] {R_WAIT, R_START, R_BITS, R_STOP} rx_state_t;

    rx_state_t      st;
    logic [1:0]     sync_q;
    logic           rx_s;
    logic [DW-1:0]  div;
    logic [2:0]     bit_i;
    logic [7:0]     sh;
    logic [TW-1:0]  tmo;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_pin};
    end
    assign rx_s = sync_q[1];

    // Character framing, mid-bit sampling and start-bit timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= R_WAIT;
            div       <= '0;
            bit_i     <= '0;
            sh        <= '0;
            tmo       <= '0;
            byte_vld  <= 1'b0;
            frame_err <= 1'b0;
            timeout   <= 1'b0;
        end else begin
            byte_vld  <= 1'b0;
            frame_err <= 1'b0;
            timeout   <= 1'b0;
            if (!arm) begin
                st  <= R_WAIT;
                tmo <= '0;
                div <= '0;
            end else begin
                case (st)
                    R_WAIT: begin
                        if (!rx_s) begin
                            st  <= R_START;
                            div <= '0;
                            tmo <= '0;
                        end else if (tmo == TW'(TMO_CYC - 1)) begin
                            timeout <= 1'b1;
                            tmo     <= '0;
                        end else begin
                            tmo <= tmo + TW'(1);
                        end
                    end
                    R_START: begin
                        if (div == DW'(HALF - 1)) begin
                            div   <= '0;
                            bit_i <= '0;
                            st    <= rx_s ? R_WAIT : R_BITS;
                        end else begin
                            div <= div + DW'(1);
                        end
                    end
                    R_BITS: begin
                        if (div == DW'(BIT_DIV - 1)) begin
                            div   <= '0;
                            sh    <= {rx_s, sh[7:1]};
                            bit_i <= bit_i + 3'd1;
                            if (bit_i == 3'd7) st <= R_STOP;
                        end else begin
                            div <= div + DW'(1);
                        end
                    end
                    default: begin
                        if (div == DW'(BIT_DIV - 1)) begin
                            div <= '0;
                            if (rx_s) byte_vld  <= 1'b1;
                            else      frame_err <= 1'b1;
                            st <= R_WAIT;
                        end else begin
                            div <= div + DW'(1);
                        end
                    end
                endcase
            end
        end
    end

    assign byte_data = sh;

    // R9: a timeout only comes from a receiver that was armed.
    assert_tmo_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> $past(arm));

    // R8: at most one event is reported per clock.
    assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({byte_vld, frame_err, timeout}));

endmodule

// File: rtl/lin_frame_seq.sv
// Frame sequencer for the LIN master.
// On start it latches direction, protected identifier, length and checksum
// seed. It then drives the serializer through break, sync and identifier,
// and next either sends the payload and checksum or collects the payload and
// checks the checksum. It ends with a one-clock fin_ok or fin_err pulse.
// Start requests are only taken in the idle state.
module lin_frame_seq #(
    parameter int BREAK_BITS = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          dir,
    input  logic                          enh,
    input  logic [5:0]                    id,
    input  logic [3:0]                    len_nib,
    output logic [2:0]                    buf_rd_idx,
    input  logic [7:0]                    buf_rd_data,
    output logic                          buf_wr,
    output logic [2:0]                    buf_wr_idx,
    output logic [7:0]                    buf_wr_data,
    output logic                          tx_go,
    output logic [lin_pkg::PAT_W-1:0]     tx_pat,
    output logic [$clog2(lin_pkg::PAT_W+1)-1:0] tx_nbits,
    input  logic                          tx_done,
    output logic                          rx_arm,
    input  logic                          rx_vld,
    input  logic [7:0]                    rx_data,
    input  logic                          rx_ferr,
    input  logic                          rx_tmo,
    output logic                          fin_ok,
    output logic                          fin_err
);
    import lin_pkg::*;

    localparam int NW = $clog2(PAT_W + 1);
    localparam logic [PAT_W-1:0] BRK_PAT = PAT_W'(1) << BREAK_BITS;

    seq_state_t  state;
    logic        launched;
    logic        dir_q;
    logic [7:0]  pid_q;
    logic [3:0]  nbytes;
    logic [3:0]  idx;
    logic [7:0]  acc;
    logic        sending;
    logic [7:0]  tx_byte;

    // Select what the serializer sends in each header and transmit state.
    always_comb begin
        sending = 1'b1;
        tx_byte = 8'h55;
        case (state)
            S_PID:   tx_byte = pid_q;
            S_TXD:   tx_byte = buf_rd_data;
            S_TXC:   tx_byte = ~acc;
            S_SYN, S_BRK: tx_byte = 8'h55;
            default: sending = 1'b0;
        endcase
        if (state == S_BRK) begin
            tx_pat   = BRK_PAT;
            tx_nbits = NW'(BREAK_BITS + 1);
        end else begin
            tx_pat   = PAT_W'({1'b1, tx_byte, 1'b0});
            tx_nbits = NW'(10);
        end
    end

    assign tx_go      = sending && !launched;
    assign rx_arm     = (state == S_RXD) || (state == S_RXC);
    assign buf_rd_idx = idx[2:0];

    // Advance through the frame, accumulate the checksum, store received bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            launched    <= 1'b0;
            dir_q       <= 1'b0;
            pid_q       <= '0;
            nbytes      <= '0;
            idx         <= '0;
            acc         <= '0;
            buf_wr      <= 1'b0;
            buf_wr_idx  <= '0;
            buf_wr_data <= '0;
            fin_ok      <= 1'b0;
            fin_err     <= 1'b0;
        end else begin
            fin_ok  <= 1'b0;
            fin_err <= 1'b0;
            buf_wr  <= 1'b0;
            if (tx_go) launched <= 1'b1;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        dir_q    <= dir;
                        pid_q    <= lin_pid(id);
                        nbytes   <= lin_len(len_nib, id);
                        acc      <= enh ? lin_pid(id) : 8'h00;
                        idx      <= '0;
                        launched <= 1'b0;
                        state    <= S_BRK;
                    end
                end
                S_BRK: if (tx_done) begin
                    launched <= 1'b0;
                    state    <= S_SYN;
                end
                S_SYN: if (tx_done) begin
                    launched <= 1'b0;
                    state    <= S_PID;
                end
                S_PID: if (tx_done) begin
                    launched <= 1'b0;
                    if (dir_q) state <= (nbytes == 4'd0) ? S_TXC : S_TXD;
                    else       state <= (nbytes == 4'd0) ? S_RXC : S_RXD;
                end
                S_TXD: if (tx_done) begin
                    launched <= 1'b0;
                    acc      <= csum_add(acc, buf_rd_data);
                    idx      <= idx + 4'd1;
                    if (idx == nbytes - 4'd1) state <= S_TXC;
                end
                S_TXC: if (tx_done) begin
                    launched <= 1'b0;
                    fin_ok   <= 1'b1;
                    state    <= S_IDLE;
                end
                S_RXD: begin
                    if (rx_ferr || rx_tmo) begin
                        fin_err <= 1'b1;
                        state   <= S_IDLE;
                    end else if (rx_vld) begin
                        buf_wr      <= 1'b1;
                        buf_wr_idx  <= idx[2:0];
                        buf_wr_data <= rx_data;
                        acc         <= csum_add(acc, rx_data);
                        idx         <= idx + 4'd1;
                        if (idx == nbytes - 4'd1) state <= S_RXC;
                    end
                end
                S_RXC: begin
                    if (rx_ferr || rx_tmo) begin
                        fin_err <= 1'b1;
                        state   <= S_IDLE;
                    end else if (rx_vld) begin
                        if (rx_data == ~acc) fin_ok  <= 1'b1;
                        else                 fin_err <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R1: the identifier is always sent straight after the sync byte.
    assert_hdr_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PID && $past(state) != S_PID) |-> $past(state) == S_SYN);

    // R4: a frame never carries more than eight payload bytes.
    assert_len_le8_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> nbytes <= 4'd8);

    // R7: the receiver is armed only for receive frames.
    assert_rx_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_arm |-> !dir_q);

    // R11: a start while busy never restarts the header.
    assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && start) |=> (state != S_BRK || $past(state) == S_BRK));

endmodule

// File: rtl/lin_master_ctl.sv
// LIN master frame engine, top level.
// Holds the register window (payload buffer, control, size, identifier,
// status) and the interrupt. It connects the frame sequencer, the serializer
// and the byte receiver. Register reads are combinational from reg_addr.
// Assumes one register access per clock, from software.
module lin_master_ctl #(
    parameter int BIT_DIV      = 16,
    parameter int BREAK_BITS   = 13,
    parameter int TIMEOUT_BITS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       lin_tx,
    input  logic       lin_rx,
    output logic       irq
);
    import lin_pkg::*;

    localparam int NW = $clog2(PAT_W + 1);

    logic [7:0]       buf_q [NBUF];
    logic             dir_q, enh_q, done_q, err_q, irq_q;
    logic [3:0]       len_q;
    logic [5:0]       id_q;
    logic             wr_ctrl, start_req, dir_now;
    logic [2:0]       rd_idx, wr_idx;
    logic             seq_wr;
    logic [7:0]       seq_wdata;
    logic             tx_go, tx_done;
    logic [PAT_W-1:0] tx_pat;
    logic [NW-1:0]    tx_nbits;
    logic             rx_arm, rx_vld, rx_ferr, rx_tmo;
    logic [7:0]       rx_data;
    logic             fin_ok, fin_err;

    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign start_req = wr_ctrl && reg_wdata[C_START];
    assign dir_now   = wr_ctrl ? reg_wdata[C_DIR] : dir_q;

    // One payload byte register per slot, written by software or the receiver.
    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (reg_wr && reg_addr == 4'(g))
                byte_q <= reg_wdata;
            else if (seq_wr && wr_idx == 3'(g))
                byte_q <= seq_wdata;
        end
        assign buf_q[g] = byte_q;
    end

    // Configuration registers written through the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            enh_q <= 1'b0;
            len_q <= '0;
            id_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: dir_q <= reg_wdata[C_DIR];
                A_SIZE: begin
                    enh_q <= reg_wdata[7];
                    len_q <= reg_wdata[3:0];
                end
                A_IDEN: id_q <= reg_wdata[5:0];
                default: ;
            endcase
        end
    end

    // Completion flags and interrupt: software clears first, frame end sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_ctrl && reg_wdata[C_CLRIRQ]) begin
                irq_q  <= 1'b0;
                done_q <= 1'b0;
            end
            if (wr_ctrl && reg_wdata[C_CLRERR]) err_q <= 1'b0;
            if (fin_ok)  begin done_q <= 1'b1; irq_q <= 1'b1; end
            if (fin_err) begin err_q  <= 1'b1; irq_q <= 1'b1; end
        end
    end

    // Read mux for the register window.
    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr < 4'(NBUF)) begin
            reg_rdata = buf_q[reg_addr[2:0]];
        end else begin
            case (reg_addr)
                A_CTRL:  reg_rdata = {2'b00, dir_q, 5'b0};
                A_STAT:  reg_rdata = {5'b0, err_q, 1'b0, done_q};
                A_SIZE:  reg_rdata = {enh_q, 3'b0, len_q};
                A_IDEN:  reg_rdata = {2'b00, id_q};
                default: reg_rdata = 8'h00;
            endcase
        end
    end

    assign irq = irq_q;

    lin_frame_seq #(.BREAK_BITS(BREAK_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start_req), .dir(dir_now),
        .enh(enh_q), .id(id_q), .len_nib(len_q),
        .buf_rd_idx(rd_idx), .buf_rd_data(buf_q[rd_idx]),
        .buf_wr(seq_wr), .buf_wr_idx(wr_idx), .buf_wr_data(seq_wdata),
        .tx_go(tx_go), .tx_pat(tx_pat), .tx_nbits(tx_nbits), .tx_done(tx_done),
        .rx_arm(rx_arm), .rx_vld(rx_vld), .rx_data(rx_data),
        .rx_ferr(rx_ferr), .rx_tmo(rx_tmo),
        .fin_ok(fin_ok), .fin_err(fin_err)
    );

    lin_bit_tx #(.BIT_DIV(BIT_DIV)) u_tx (
        .clk(clk), .rst_n(rst_n), .go(tx_go), .pat(tx_pat),
        .nbits(tx_nbits), .done(tx_done), .line(lin_tx)
    );

    lin_byte_rx #(.BIT_DIV(BIT_DIV), .TIMEOUT_BITS(TIMEOUT_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .arm(rx_arm), .rx_pin(lin_rx),
        .byte_vld(rx_vld), .byte_data(rx_data),
        .frame_err(rx_ferr), .timeout(rx_tmo)
    );

    // R10: the interrupt only rises together with a done or error flag.
    assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> (done_q || err_q));

endmodule

// File: tb/sim_lin_master_ctl.sv
// Bench for lin_master_ctl: decodes the transmit line, plays a slave on the
// receive line, and compares against values computed from the requirements.
module sim_lin_master_ctl;
    localparam int BD     = 4;
    localparam int BRK    = 13;
    localparam int TMO    = 20;
    localparam int WD_MAX = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       lin_tx;
    logic       lin_rx = 1'b1;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [7:0] cap [16];
    int cap_n = 0;
    int brk_len = 0;
    int brk_cnt = 0;

    always #4 clk = ~clk;

    lin_master_ctl #(.BIT_DIV(BD), .BREAK_BITS(BRK), .TIMEOUT_BITS(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lin_tx(lin_tx),
        .lin_rx(lin_rx), .irq(irq)
    );

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WD_MAX) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WD_MAX);
                report();
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    // Transmit line decoder: classifies long lows as break, else bytes.
    initial begin
        logic [9:0] bits;
        int low;
        bit still;
        forever begin
            while (!(rst_n && lin_tx === 1'b0)) @(negedge clk);
            low = 0; still = 1; bits = '0;
            for (int k = 0; k < 10 * BD; k++) begin
                if (k % BD == BD / 2) bits[k / BD] = lin_tx;
                if (still && lin_tx == 1'b0) low++; else still = 0;
                @(negedge clk);
            end
            if (bits[9] == 1'b0) begin
                while (lin_tx == 1'b0) begin low++; @(negedge clk); end
                brk_len = low;
                brk_cnt++;
            end else if (cap_n < 16) begin
                cap[cap_n] = bits[8:1];
                cap_n++;
            end
        end
    end

    function automatic logic [7:0] m_pid(input logic [5:0] i);
        logic a, b;
        a = i[0] ^ i[1] ^ i[2] ^ i[4];
        b = !(i[1] ^ i[3] ^ i[4] ^ i[5]);
        return {b, a, i};
    endfunction

    function automatic int m_len(input logic [3:0] nib, input logic [5:0] i);
        if (nib == 4'hF) return (i[5:4] == 2'b11) ? 8 : (i[5:4] == 2'b10) ? 4 : 2;
        return (nib > 8) ? 8 : int'(nib);
    endfunction

    function automatic logic [7:0] m_sum(input int s, input logic [7:0] b);
        int t;
        t = s + b;
        if (t > 255) t = t - 255;
        return 8'(t);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_irq(output bit ok);
        ok = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (irq) begin ok = 1; break; end
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stopv);
        logic [9:0] f;
        f = {stopv, b, 1'b0};
        for (int j = 0; j < 10; j++) begin
            lin_rx = f[j];
            repeat (BD) @(negedge clk);
        end
        lin_rx = 1'b1;
    endtask

    // Transmit frame: checks header, payload order and checksum on the line.
    task automatic tx_frame(input logic [5:0] id, input logic [3:0] nib,
                            input bit enh, input bit poke);
        logic [7:0] d [8];
        logic [7:0] acc, s;
        int n;
        bit ok;
        n = m_len(nib, id);
        for (int i = 0; i < 8; i++) begin
            d[i] = 8'(int'(id) * 29 + i * 13 + int'(nib) * 7 + 1);
            wr(4'(i), d[i]);
        end
        wr(4'hE, {2'b00, id});
        wr(4'hB, {enh, 3'b000, nib});
        cap_n = 0; brk_cnt = 0;
        wr(4'h8, 8'h21);
        if (poke) begin
            repeat (20 * BD) @(negedge clk);
            wr(4'h8, 8'h21);
        end
        wait_irq(ok);
        chk(ok, "R5 frame end irq", int'(ok), 1);
        chk(brk_len == BRK * BD, "R1 break length", brk_len, BRK * BD);
        chk(cap_n == n + 3, "R4 byte count on line", cap_n, n + 3);
        chk(cap[0] == 8'h55, "R1 sync byte", cap[0], 8'h55);
        chk(cap[1] == m_pid(id), "R2 protected id", cap[1], m_pid(id));
        acc = enh ? m_pid(id) : 8'h00;
        for (int i = 0; i < n; i++) begin
            chk(cap[2 + i] == d[i], "R5 payload order", cap[2 + i], d[i]);
            acc = m_sum(int'(acc), d[i]);
        end
        chk(cap[2 + n] == ~acc, "R6 checksum", cap[2 + n], ~acc);
        if (poke) begin
            repeat (30 * BD) @(negedge clk);
            chk(brk_cnt == 1 && lin_tx == 1'b1, "R11 busy start ignored", brk_cnt, 1);
        end
        rd(4'h9, s);
        chk(s == 8'h01, "R10 done status", s, 8'h01);
        wr(4'h8, 8'h0C);
        chk(irq == 1'b0, "R10 irq cleared", int'(irq), 0);
    endtask

    // Receive frame: mode 0 good, 1 bad checksum, 2 low stop bit, 3 silent.
    task automatic rx_frame(input logic [5:0] id, input logic [3:0] nib,
                            input bit enh, input int mode);
        logic [7:0] d [8];
        logic [7:0] acc, s, b;
        int n;
        bit ok;
        n = m_len(nib, id);
        acc = enh ? m_pid(id) : 8'h00;
        for (int i = 0; i < n; i++) begin
            d[i] = 8'(int'(id) * 31 + i * 17 + 5);
            acc = m_sum(int'(acc), d[i]);
        end
        wr(4'hE, {2'b00, id});
        wr(4'hB, {enh, 3'b000, nib});
        cap_n = 0;
        wr(4'h8, 8'h01);
        if (mode != 3) begin
            for (int k = 0; k < 2000 && cap_n < 2; k++) @(negedge clk);
            repeat (2 * BD) @(negedge clk);
            for (int i = 0; i <= n; i++) begin
                b = (i < n) ? d[i] : (~acc ^ ((mode == 1) ? 8'h01 : 8'h00));
                send_byte(b, !(mode == 2 && i == 0));
                if (mode == 2) break;
            end
        end
        wait_irq(ok);
        chk(ok, "R9 receive frame ends", int'(ok), 1);
        rd(4'h9, s);
        if (mode == 0) begin
            chk(s == 8'h01, "R7 good receive done", s, 8'h01);
            for (int i = 0; i < n; i++) begin
                rd(4'(i), b);
                chk(b == d[i], "R7 stored byte", b, d[i]);
            end
        end else if (mode == 1) begin
            chk(s == 8'h04, "R8 checksum mismatch error", s, 8'h04);
        end else if (mode == 2) begin
            chk(s == 8'h04, "R8 stop bit error", s, 8'h04);
        end else begin
            chk(s == 8'h04, "R9 timeout error", s, 8'h04);
        end
        wr(4'h8, 8'h0C);
        rd(4'h9, s);
        chk(s == 8'h00 && irq == 1'b0, "R10 full clear", s, 0);
    endtask

    initial begin
        logic [7:0] v;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 1'b0 && lin_tx == 1'b1, "R10 reset irq low, line idle", int'(irq), 0);
        rd(4'h9, v); chk(v == 8'h00, "R10 reset status", v, 0);
        rd(4'h8, v); chk(v == 8'h00, "R3 reset control", v, 0);

        // R3: register window readback.
        for (int i = 0; i < 8; i++) wr(4'(i), 8'(8'hA0 + i * 9));
        for (int i = 0; i < 8; i++) begin
            rd(4'(i), v);
            chk(v == 8'(8'hA0 + i * 9), "R3 buffer readback", v, 8'(8'hA0 + i * 9));
        end
        wr(4'hE, 8'hFF); rd(4'hE, v); chk(v == 8'h3F, "R3 id width", v, 8'h3F);
        wr(4'hB, 8'hFA); rd(4'hB, v); chk(v == 8'h8A, "R3 size bits", v, 8'h8A);
        wr(4'h8, 8'h20); rd(4'h8, v); chk(v == 8'h20, "R3 direction readback", v, 8'h20);
        wr(4'h8, 8'h00);

        // R2 R4 R5 R6: every identifier with decoded length.
        for (int i = 0; i < 64; i++) tx_frame(6'(i), 4'hF, i[0], 1'b0);
        // R4: every explicit size code, including clamped ones.
        for (int nb = 0; nb < 15; nb++) tx_frame(6'h2A, 4'(nb), nb[1], 1'b0);
        // R11: start while busy.
        tx_frame(6'h13, 4'd3, 1'b1, 1'b1);

        // R7: receive for each length and both checksum types.
        for (int nb = 0; nb <= 8; nb++) begin
            rx_frame(6'(nb * 7), 4'(nb), 1'b0, 0);
            rx_frame(6'(nb * 5 + 1), 4'(nb), 1'b1, 0);
        end
        rx_frame(6'h31, 4'hF, 1'b1, 0);
        // R8 and R9: error cases.
        rx_frame(6'h05, 4'd3, 1'b0, 1);
        rx_frame(6'h22, 4'd4, 1'b1, 1);
        rx_frame(6'h07, 4'd2, 1'b0, 2);
        rx_frame(6'h09, 4'd0, 1'b1, 2);
        rx_frame(6'h0B, 4'd2, 1'b0, 3);

        // R10: clearing error alone keeps the interrupt raised.
        wr(4'hE, 8'h01); wr(4'hB, 8'h01); wr(4'h8, 8'h01);
        wait_irq(ok);
        chk(ok, "R9 silent frame ends", int'(ok), 1);
        wr(4'h8, 8'h04);
        rd(4'h9, v);
        chk(v == 8'h00 && irq == 1'b1, "R10 error clear keeps irq", {irq, v}, 9'h100);
        wr(4'h8, 8'h08);
        chk(irq == 1'b0, "R10 irq clear", int'(irq), 0);

        report();
    end

endmodule